// File: doc/BRIEF.md
# Byte-Buffered 16-bit PWM Channel

This block is one compare channel of a counter array, set up for pulse-width modulation with a 16-bit compare value. A shared timebase supplies the running counter value, a strobe that marks each counter advance, and an overflow strobe. Software loads the compare value as two byte-wide register writes. The channel drives one PWM pin from a set/reset output stage. A compare match sets the pin and a counter overflow clears it, so the compare value sets the duty cycle.

An arming state machine decides whether the comparator may act. A low-byte write puts it in the `ARM_HALF` state, where the comparator is disabled. A high-byte write moves it to `ARM_ON`, where the comparator is enabled. After reset it starts in `ARM_OFF`, which is also disabled. Transitions: `ARM_OFF`/`ARM_ON` go to `ARM_HALF` on a low write. Any state goes to `ARM_ON` on a high write, and a high write wins when both writes arrive together. Because software writes the low byte first, a half-written compare value can never cause a false match.

The output stage has two states. `OUT_LOW` goes to `OUT_HIGH` on a qualified match with no overflow. `OUT_HIGH` goes to `OUT_LOW` on an overflow, and an overflow also keeps the stage in `OUT_LOW`. A sticky interrupt flag records match and clear events when interrupts are enabled.

Top module: `pwm16_channel`

## Requirements
- R1: A low-byte write (`wr_lo`=1 without `wr_hi`) stores `wr_data` into compare bits 7:0 and disables the comparator from the next cycle.
- R2: A high-byte write (`wr_hi`=1) stores `wr_data` into compare bits 15:8 and enables the comparator from the next cycle. When both writes occur in one cycle, both bytes are stored and the comparator ends up enabled.
- R3: When the comparator is enabled, the mode is valid, `cnt_adv`=1 and `cnt_val` equals the compare value, `pwm_out` is 1 from the next cycle on, unless an overflow occurs in the same cycle.
- R4: `cnt_ovf`=1 drives `pwm_out` to 0 in the next cycle. The overflow wins over a match in the same cycle.
- R5: The mode is valid only when `mode_pwm16`=1 and `mode_cap_pos`, `mode_cap_neg` and `mode_toggle` are all 0. With any other combination, no match can set `pwm_out`.
- R6: No match is detected in a cycle where `cnt_adv`=0, even if the counter equals the compare value.
- R7: While the comparator is disabled (after reset, or after a low write that has no following high write), equality never sets `pwm_out`.
- R8: `irq_flag` becomes 1 in the next cycle when `irq_en`=1 and either a qualified match occurs or an overflow occurs while the mode is valid. `irq_clr`=1 clears the flag, and setting wins over clearing.
- R9: With the timebase convention that the overflow strobe comes with the counter value 0, a compare value of 0 keeps `pwm_out` at 0.
- R10: After reset, `pwm_out`=0, `irq_flag`=0, the compare value is 0 and the comparator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Shared timebase counter value |
| cnt_adv | input | 1 | Counter advances this cycle |
| cnt_ovf | input | 1 | Counter overflow strobe |
| wr_lo | input | 1 | Write low compare byte |
| wr_hi | input | 1 | Write high compare byte |
| wr_data | input | 8 | Byte written to the compare register |
| mode_pwm16 | input | 1 | 16-bit PWM mode bit |
| mode_cap_pos | input | 1 | Rising-edge capture mode bit |
| mode_cap_neg | input | 1 | Falling-edge capture mode bit |
| mode_toggle | input | 1 | Toggle mode bit |
| irq_en | input | 1 | Interrupt flag enable |
| irq_clr | input | 1 | Clear interrupt flag |
| pwm_out | output | 1 | PWM output pin |
| irq_flag | output | 1 | Sticky capture/compare interrupt flag |

## Verification
The bench sweeps compare values across the whole 16-bit range. For each value it drives the counter just below, at and above the value, and then an overflow at count 0. If a design compared only one byte, or stored the bytes swapped, it would set the pin at the wrong count. A directed half-write phase puts a matching value on the counter after only a low write: a design that did not disarm would raise the pin. Other directed phases put a match and an overflow in the same cycle, and load a compare value of 0. Getting the priority wrong would leave the pin high, where it should stay low. A long pseudo-random phase varies the mode bits, the advance strobe, the interrupt controls and the write ordering, and checks every cycle against an arithmetic model.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ARM_OFF  = 2'd0,
        ARM_HALF = 2'd1,
        ARM_ON   = 2'd2
    } arm_state_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;
endpackage

// File: rtl/pwm16_cmp_reg.sv
module pwm16_cmp_reg
    import pwm16_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              armed
);
    localparam int unsigned HI_W = CNT_W - BYTE_W;

    arm_state_e state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    // arming state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_OFF;
        else        state_q <= state_d;
    end

    // arming transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_OFF: begin
                if (wr_hi)      state_d = ARM_ON;
                else if (wr_lo) state_d = ARM_HALF;
            end
            ARM_HALF: begin
                if (wr_hi)      state_d = ARM_ON;
            end
            ARM_ON: begin
                if (wr_lo && !wr_hi) state_d = ARM_HALF;
            end
            default: state_d = ARM_OFF;
        endcase
    end

    // compare byte storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= HI_W'(wr_data);
        end
    end

    // outputs
    always_comb begin
        cmp_val = {hi_q, lo_q};
        armed   = (state_q == ARM_ON);
    end

    // R1
    lo_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (!armed && cmp_val[BYTE_W-1:0] == $past(wr_data)));

    // R2
    hi_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (armed && cmp_val[CNT_W-1:BYTE_W] == HI_W'($past(wr_data))));
endmodule

// File: rtl/pwm16_match.sv
module pwm16_match #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             armed,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_adv,
    input  logic             mode_pwm16,
    input  logic             mode_cap_pos,
    input  logic             mode_cap_neg,
    input  logic             mode_toggle,
    output logic             mode_ok,
    output logic             match
);
    logic equal;

    always_comb begin
        mode_ok = mode_pwm16 & ~mode_cap_pos & ~mode_cap_neg & ~mode_toggle;
        equal   = (cnt_val == cmp_val);
        match   = mode_ok & armed & cnt_adv & equal;
    end
endmodule

// File: rtl/pwm16_out_latch.sv
module pwm16_out_latch
    import pwm16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic cnt_ovf,
    input  logic mode_ok,
    input  logic irq_en,
    input  logic irq_clr,
    output logic pwm_out,
    output logic irq_flag
);
    out_state_e state_q, state_d;
    logic flag_q, flag_d;
    logic clr_evt;

    // output state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_LOW;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // transitions: overflow clear beats match set
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW:  if (set_evt && !cnt_ovf) state_d = OUT_HIGH;
            OUT_HIGH: if (cnt_ovf)             state_d = OUT_LOW;
            default:  state_d = OUT_LOW;
        endcase
    end

    // interrupt flag next value
    always_comb begin
        clr_evt = cnt_ovf & mode_ok;
        flag_d  = flag_q;
        if (irq_en && (set_evt || clr_evt)) flag_d = 1'b1;
        else if (irq_clr)                   flag_d = 1'b0;
    end

    // outputs
    always_comb begin
        pwm_out  = (state_q == OUT_HIGH);
        irq_flag = flag_q;
    end

    // R4
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |=> !pwm_out);

    // R3
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !cnt_ovf) |=> pwm_out);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (set_evt || (cnt_ovf && mode_ok))) |=> irq_flag);
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
    import pwm16_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_adv,
    input  logic              cnt_ovf,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              mode_pwm16,
    input  logic              mode_cap_pos,
    input  logic              mode_cap_neg,
    input  logic              mode_toggle,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              pwm_out,
    output logic              irq_flag
);
    logic [CNT_W-1:0] cmp_val;
    logic armed, mode_ok, match;

    pwm16_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cmp_val (cmp_val),
        .armed   (armed)
    );

    pwm16_match #(.CNT_W(CNT_W)) u_match (
        .armed        (armed),
        .cnt_val      (cnt_val),
        .cmp_val      (cmp_val),
        .cnt_adv      (cnt_adv),
        .mode_pwm16   (mode_pwm16),
        .mode_cap_pos (mode_cap_pos),
        .mode_cap_neg (mode_cap_neg),
        .mode_toggle  (mode_toggle),
        .mode_ok      (mode_ok),
        .match        (match)
    );

    pwm16_out_latch u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (match),
        .cnt_ovf  (cnt_ovf),
        .mode_ok  (mode_ok),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .pwm_out  (pwm_out),
        .irq_flag (irq_flag)
    );

    // R5
    bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mode_pwm16 && !mode_cap_pos && !mode_cap_neg && !mode_toggle) && !pwm_out)
        |=> !pwm_out);

    // R6
    no_adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_adv && !pwm_out) |=> !pwm_out);
endmodule

// File: tb/pwm16_channel_tb_top.sv
`timescale 1ns/1ps
module pwm16_channel_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic cnt_adv = 0, cnt_ovf = 0, wr_lo = 0, wr_hi = 0;
    logic [7:0] wr_data = '0;
    logic mode_pwm16 = 1, mode_cap_pos = 0, mode_cap_neg = 0, mode_toggle = 0;
    logic irq_en = 0, irq_clr = 0;
    logic pwm_out, irq_flag;

    int total = 0;
    int bad = 0;

    // reference model state
    logic        m_en = 0;
    logic [15:0] m_cmp = '0;
    logic        m_q = 0;
    logic        m_flag = 0;

    always #2.5 clk = ~clk;

    pwm16_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_adv(cnt_adv),
        .cnt_ovf(cnt_ovf), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .mode_pwm16(mode_pwm16), .mode_cap_pos(mode_cap_pos),
        .mode_cap_neg(mode_cap_neg), .mode_toggle(mode_toggle),
        .irq_en(irq_en), .irq_clr(irq_clr), .pwm_out(pwm_out), .irq_flag(irq_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // one cycle: inputs already driven at a negedge; advance the model, wait, compare
    task automatic step(input string req);
        logic mode_ok, m;
        mode_ok = mode_pwm16 & ~mode_cap_pos & ~mode_cap_neg & ~mode_toggle;
        m = mode_ok & m_en & cnt_adv & (cnt_val == m_cmp);
        if (irq_en && (m || (cnt_ovf && mode_ok))) m_flag = 1'b1;
        else if (irq_clr)                          m_flag = 1'b0;
        if (cnt_ovf) m_q = 1'b0;
        else if (m)  m_q = 1'b1;
        if (wr_lo) m_cmp[7:0]  = wr_data;
        if (wr_hi) m_cmp[15:8] = wr_data;
        if (wr_hi)      m_en = 1'b1;
        else if (wr_lo) m_en = 1'b0;
        @(negedge clk);
        check(req, pwm_out, m_q);
        check(req, irq_flag, m_flag);
        wr_lo = 0; wr_hi = 0; irq_clr = 0;
    endtask

    task automatic load(input logic [15:0] v, input string req);
        wr_lo = 1; wr_data = v[7:0]; step(req);
        wr_hi = 1; wr_data = v[15:8]; step(req);
    endtask

    task automatic count(input logic [15:0] c, input logic adv, input logic ovf,
                         input string req);
        cnt_val = c; cnt_adv = adv; cnt_ovf = ovf; step(req);
        cnt_adv = 0; cnt_ovf = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] cv;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", pwm_out, 1'b0);
        check("R10", irq_flag, 1'b0);
        rst_n = 1;
        @(negedge clk);
        // R10/R7: compare reset 0 but disarmed, equality at 0 must not set
        count(16'h0000, 1, 0, "R7");
        count(16'h0000, 1, 0, "R10");

        // R1 R2 R3 R4: sweep compare values across the range
        for (int i = 0; i < 128; i++) begin
            cv = 16'(i * 16'd521 + (i & 1) * 16'hFF00);
            if (i == 127) cv = 16'hFFFF;
            if (i == 126) cv = 16'h0001;
            load(cv, "R2");
            count(cv - 16'd1, 1, 0, "R3");
            count(cv,         1, 0, "R3");
            count(cv + 16'd1, 1, 0, "R3");
            count(16'h0000,   1, 1, "R4");
            count(16'h0001,   1, 0, "R4");
        end

        // R7: half-written value must not match
        load(16'h1234, "R2");
        wr_lo = 1; wr_data = 8'h78; step("R1");
        count(16'h1278, 1, 0, "R7");
        count(16'h1234, 1, 0, "R7");
        check("R7", pwm_out, 1'b0);
        wr_hi = 1; wr_data = 8'h12; step("R2");
        count(16'h1278, 1, 0, "R7");
        check("R3", pwm_out, 1'b1);
        count(16'h0000, 1, 1, "R4");

        // R2: both bytes in one cycle
        wr_lo = 1; wr_hi = 1; wr_data = 8'h5A; step("R2");
        count(16'h5A5A, 1, 0, "R2");
        check("R2", pwm_out, 1'b1);

        // R4: match and overflow together
        count(16'h0000, 1, 1, "R4");
        count(16'h5A5A, 1, 1, "R4");
        check("R4", pwm_out, 1'b0);

        // R6: equality without advance
        count(16'h5A5A, 0, 0, "R6");
        check("R6", pwm_out, 1'b0);

        // R5: each invalid mode combination
        for (int k = 1; k < 16; k++) begin
            if (k == 8) continue;
            {mode_pwm16, mode_cap_pos, mode_cap_neg, mode_toggle} = 4'(k);
            count(16'h5A5A, 1, 0, "R5");
            check("R5", pwm_out, 1'b0);
        end
        {mode_pwm16, mode_cap_pos, mode_cap_neg, mode_toggle} = 4'b1000;

        // R8: interrupt flag set, clear, set-wins
        irq_en = 1;
        count(16'h5A5A, 1, 0, "R8");
        check("R8", irq_flag, 1'b1);
        irq_en = 0; irq_clr = 1; count(16'h0003, 1, 0, "R8");
        check("R8", irq_flag, 1'b0);
        irq_en = 1; irq_clr = 1; count(16'h0000, 1, 1, "R8");
        check("R8", irq_flag, 1'b1);
        irq_en = 0; irq_clr = 1; count(16'h0004, 1, 0, "R8");

        // R9: compare 0 stays low over full short periods
        load(16'h0000, "R9");
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 40; c++) begin
                count(16'(c), 1, (c == 0), "R9");
                check("R9", pwm_out, 1'b0);
            end
        end

        // pseudo-random phase over all inputs
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_lo   = (lfsr[3:0] == 4'd1);
            wr_hi   = (lfsr[3:0] == 4'd2) || (lfsr[3:0] == 4'd1 && lfsr[9]);
            wr_data = lfsr[15:8];
            {mode_pwm16, mode_cap_pos, mode_cap_neg, mode_toggle} =
                (lfsr[6:4] == 3'd0) ? lfsr[15:12] : 4'b1000;
            irq_en  = lfsr[7];
            irq_clr = lfsr[11];
            cnt_adv = (lfsr[2:1] != 2'd0);
            cnt_ovf = (lfsr[8:5] == 4'd3);
            cnt_val = cnt_ovf ? 16'h0000 : (m_cmp + 16'(lfsr[1:0]) - 16'd1);
            step(n[0] ? "R3" : "R8");
        end
        cnt_adv = 0; cnt_ovf = 0;
        {mode_pwm16, mode_cap_pos, mode_cap_neg, mode_toggle} = 4'b1000;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule